// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block is the source-side controller that decides when a display link may hand refresh duty to a panel holding its own copy of the frame. Software sets two control bits, an enable and an entry request. The hardware then steps through a fixed set of states:

- It counts idle frames before it claims the panel is self-refreshing.
- It can send one fresh frame while staying in self-refresh.
- On leaving, it sends a wake request to the sink and waits for that write to be acknowledged.

The state code, an in-transition flag, an active flag and the wake request are the outputs. The side-band transaction itself is outside the block and is seen as a request/acknowledge pair. The address and data of that wake write are presented on fixed outputs.

A single-frame-update request is a bit that software sets before a flip. The hardware clears it once it has acted on it. Frame-start ticks and a screen-update pulse feed the idle counter. The idle threshold is programmable but never drops below a floor of six frames.

Top module: `srf_sequencer`

## Requirements
- R1: State codes are 0 off, 1 idle, 2 entering, 3 self-refresh with no buffer update, 4 self-refresh with a single-frame update, and 5 leaving. After reset the state is 0, and active, in_trans, aux_wake_req and sfu_pending are all 0.
- R2: In state 0, cfg_enable high moves the state to 1 on the next edge. State 0 never goes straight to any other state, even when cfg_entry is already high.
- R3: In state 1 with cfg_enable high, cfg_entry high moves the state to 2 on the next edge.
- R4: In state 2, a frame_tick with no scr_update in the same cycle adds one idle frame, and scr_update resets the count to zero. The state moves to 3 on the edge of the tick that completes the required count. Dropping cfg_entry in state 2 returns the state to 1.
- R5: The required idle count is the larger of idle_prog and 6.
- R6: In state 3 or 4 with cfg_enable high, dropping cfg_entry moves the state to 5 and raises aux_wake_req on the same edge. State 4 is never entered on this path.
- R7: State 5 holds, with aux_wake_req high, until aux_wake_ack is seen. That edge moves the state to 1 and drops the request. aux_wake_addr reads 0x600 and aux_wake_data reads 0x01.
- R8: A sfu_set pulse sets sfu_pending in any state except 0. The bit clears itself on the edge that moves 2 to 3 or 3 to 4, and on any move to state 0. In state 0 the pulse is ignored.
- R9: In state 3 with sfu_pending high, the next edge moves to state 4. State 4 returns to state 3 on the next frame_tick.
- R10: active is high exactly in states 3 and 4.
- R11: in_trans is high in states 2 and 5 and whenever aux_wake_req is high.
- R12: With cfg_enable low, states 1, 3 and 4 go to 0 on the next edge. States 2 and 5 first finish their transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Self-refresh enable bit |
| cfg_entry | input | 1 | Request to enter self-refresh |
| sfu_set | input | 1 | Pulse that sets the single-frame-update bit |
| frame_tick | input | 1 | Frame-start pulse |
| scr_update | input | 1 | Screen content changed this cycle |
| idle_prog | input | IDLE_W | Programmed idle-frame threshold |
| aux_wake_ack | input | 1 | Sink wake write completed |
| state_code | output | 3 | Current state code |
| in_trans | output | 1 | Transition in progress |
| active | output | 1 | Panel is self-refreshing |
| aux_wake_req | output | 1 | Request for the sink wake write |
| aux_wake_addr | output | 20 | Sink address of the wake write |
| aux_wake_data | output | 8 | Data byte of the wake write |
| sfu_pending | output | 1 | Single-frame-update bit |

## Verification
The idle counter is tested with several thresholds. A threshold below the floor checks that six ticks are required. A threshold above the floor with a screen update in the middle checks that the count restarts rather than pauses. The exit path is tested with a delayed acknowledge, which separates a correct wait from an early return to idle. Disable is applied both in a steady state and during a leave, which tests whether disable waits for the transition to finish. A long run of random control, tick, update and acknowledge patterns is compared every cycle against a behavioural model. This catches priority slips between disable, exit and single-frame update.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_IDLE  = 3'd1,
    SQ_ENTER = 3'd2,
    SQ_HOLD  = 3'd3,
    SQ_SFU   = 3'd4,
    SQ_LEAVE = 3'd5
  } sq_state_e;

  // required idle frames: programmed value, never below the floor
  function automatic int unsigned floor_idle(input int unsigned prog,
                                             input int unsigned floor_v);
    floor_idle = (prog < floor_v) ? floor_v : prog;
  endfunction
endpackage

// File: rtl/srf_idle_counter.sv
`timescale 1ns/1ps
module srf_idle_counter #(
  parameter int IDLE_W   = 4,
  parameter int MIN_IDLE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              frame_tick,
  input  logic              scr_update,
  input  logic [IDLE_W-1:0] idle_prog,
  output logic              idle_done
);
  import srf_pkg::*;
  localparam int CW = IDLE_W + 1;

  logic [CW-1:0] eff_idle;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;

  assign eff_idle  = CW'(floor_idle(int'(idle_prog), MIN_IDLE));
  assign cnt_inc   = cnt_q + CW'(1);
  assign idle_done = arm && frame_tick && !scr_update && (cnt_inc >= eff_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!arm || scr_update)  cnt_q <= '0;
    else if (frame_tick)          cnt_q <= cnt_inc;
  end

  // R5
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_done |-> (cnt_q >= CW'(MIN_IDLE - 1)));
endmodule

// File: rtl/srf_sfu_flag.sv
`timescale 1ns/1ps
module srf_sfu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic set_ok,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pending <= 1'b0;
    else if (clr)                pending <= 1'b0;
    else if (set_req && set_ok)  pending <= 1'b1;
  end

  // R8
  sfu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pending);
endmodule

// File: rtl/srf_wake_hs.sv
`timescale 1ns/1ps
module srf_wake_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req <= 1'b0;
    else if (start)  req <= 1'b1;
    else if (ack)    req <= 1'b0;
  end

  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
endmodule

// File: rtl/srf_sequencer.sv
`timescale 1ns/1ps
module srf_sequencer #(
  parameter int          IDLE_W    = 4,
  parameter int          MIN_IDLE  = 6,
  parameter logic [19:0] WAKE_ADDR = 20'h00600,
  parameter logic [7:0]  WAKE_DATA = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_entry,
  input  logic              sfu_set,
  input  logic              frame_tick,
  input  logic              scr_update,
  input  logic [IDLE_W-1:0] idle_prog,
  input  logic              aux_wake_ack,
  output logic [2:0]        state_code,
  output logic              in_trans,
  output logic              active,
  output logic              aux_wake_req,
  output logic [19:0]       aux_wake_addr,
  output logic [7:0]        aux_wake_data,
  output logic              sfu_pending
);
  import srf_pkg::*;

  sq_state_e st_q, st_nx;

  // named internal events
  logic ev_idle_done;
  logic ev_exit_go;
  logic ev_wake_done;
  logic ev_sfu_go;
  logic ev_sfu_clr;

  srf_idle_counter #(.IDLE_W(IDLE_W), .MIN_IDLE(MIN_IDLE)) u_idle (
    .clk(clk), .rst_n(rst_n), .arm(st_q == SQ_ENTER),
    .frame_tick(frame_tick), .scr_update(scr_update),
    .idle_prog(idle_prog), .idle_done(ev_idle_done)
  );

  srf_sfu_flag u_sfu (
    .clk(clk), .rst_n(rst_n), .set_req(sfu_set), .set_ok(st_q != SQ_OFF),
    .clr(ev_sfu_clr), .pending(sfu_pending)
  );

  srf_wake_hs u_wake (
    .clk(clk), .rst_n(rst_n), .start(ev_exit_go), .ack(aux_wake_ack),
    .req(aux_wake_req)
  );

  assign ev_exit_go   = (st_q inside {SQ_HOLD, SQ_SFU}) && cfg_enable && !cfg_entry;
  assign ev_wake_done = (st_q == SQ_LEAVE) && aux_wake_req && aux_wake_ack;
  assign ev_sfu_go    = (st_q == SQ_HOLD) && cfg_enable && cfg_entry && sfu_pending;
  assign ev_sfu_clr   = ev_sfu_go || (st_nx == SQ_OFF) ||
                        ((st_q == SQ_ENTER) && (st_nx == SQ_HOLD));

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      SQ_OFF:   if (cfg_enable) st_nx = SQ_IDLE;
      SQ_IDLE:  if (!cfg_enable) st_nx = SQ_OFF;
                else if (cfg_entry) st_nx = SQ_ENTER;
      SQ_ENTER: if (!cfg_entry) st_nx = SQ_IDLE;
                else if (ev_idle_done) st_nx = SQ_HOLD;
      SQ_HOLD:  if (!cfg_enable) st_nx = SQ_OFF;
                else if (ev_exit_go) st_nx = SQ_LEAVE;
                else if (ev_sfu_go) st_nx = SQ_SFU;
      SQ_SFU:   if (!cfg_enable) st_nx = SQ_OFF;
                else if (ev_exit_go) st_nx = SQ_LEAVE;
                else if (frame_tick) st_nx = SQ_HOLD;
      SQ_LEAVE: if (ev_wake_done) st_nx = SQ_IDLE;
      default:  st_nx = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_OFF;
    else        st_q <= st_nx;
  end

  assign state_code    = st_q;
  assign active        = (st_q == SQ_HOLD) || (st_q == SQ_SFU);
  assign in_trans      = (st_q == SQ_ENTER) || (st_q == SQ_LEAVE) || aux_wake_req;
  assign aux_wake_addr = WAKE_ADDR;
  assign aux_wake_data = WAKE_DATA;

  // R2
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_OFF) |=> (st_q inside {SQ_OFF, SQ_IDLE}));
  // R4
  enter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_ENTER && cfg_entry && !frame_tick) |=> (st_q == SQ_ENTER));
  // R6
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q inside {SQ_HOLD, SQ_SFU}) && cfg_enable && !cfg_entry)
      |=> (st_q == SQ_LEAVE && aux_wake_req));
  // R7
  leave_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_LEAVE && !aux_wake_ack) |=> (st_q == SQ_LEAVE));
  // R12
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q inside {SQ_IDLE, SQ_HOLD, SQ_SFU}) && !cfg_enable) |=> (st_q == SQ_OFF));
  // R9
  sfu_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SFU && cfg_enable && cfg_entry && frame_tick) |=> (st_q == SQ_HOLD));
endmodule

// File: tb/srf_sequencer_tb.sv
`timescale 1ns/1ps
module srf_sequencer_tb;
  localparam int IDLE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ent = 0, sfu = 0, tick = 0, upd = 0, ack = 0;
  logic [IDLE_W-1:0] thr = '0;
  logic [2:0]  state_code;
  logic        in_trans, active, aux_wake_req, sfu_pending;
  logic [19:0] aux_wake_addr;
  logic [7:0]  aux_wake_data;

  int total = 0, bad = 0, cyc = 0;
  int m_st = 0, m_cnt = 0;
  bit m_sfu = 0, m_req = 0;

  always #4 clk = ~clk;

  srf_sequencer #(.IDLE_W(IDLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_entry(ent), .sfu_set(sfu),
    .frame_tick(tick), .scr_update(upd), .idle_prog(thr), .aux_wake_ack(ack),
    .state_code(state_code), .in_trans(in_trans), .active(active),
    .aux_wake_req(aux_wake_req), .aux_wake_addr(aux_wake_addr),
    .aux_wake_data(aux_wake_data), .sfu_pending(sfu_pending)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on every edge
  task automatic model_step();
    int nst = m_st;
    bit clr = 0;
    bit nreq = m_req;
    int need = (int'(thr) > 6) ? int'(thr) : 6;
    case (m_st)
      0: if (en) nst = 1;
      1: if (!en) nst = 0; else if (ent) begin nst = 2; m_cnt = 0; end
      2: if (!ent) nst = 1;
         else if (upd) m_cnt = 0;
         else if (tick) begin
           m_cnt++;
           if (m_cnt >= need) begin nst = 3; clr = 1; end
         end
      3: if (!en) nst = 0;
         else if (!ent) begin nst = 5; nreq = 1; end
         else if (m_sfu) begin nst = 4; clr = 1; end
      4: if (!en) nst = 0;
         else if (!ent) begin nst = 5; nreq = 1; end
         else if (tick) nst = 3;
      5: if (ack && m_req) begin nst = 1; nreq = 0; end
      default: nst = 0;
    endcase
    if (nst == 0) clr = 1;
    if (!nreq && m_st != 5 && ack) nreq = 0;
    if (clr) m_sfu = 0;
    else if (sfu && m_st != 0) m_sfu = 1;
    m_st = nst;
    m_req = nreq;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sfu = 0; m_req = 0;
    end else begin
      model_step();
    end
    #2;
    chk("R1 model state", int'(state_code), m_st);
    chk("R10 model active", int'(active), int'(m_st == 3 || m_st == 4));
    chk("R11 model in_trans", int'(in_trans), int'(m_st == 2 || m_st == 5 || m_req));
    chk("R7 model wake req", int'(aux_wake_req), int'(m_req));
    chk("R8 model sfu bit", int'(sfu_pending), int'(m_sfu));
    if (cyc > 150000) begin
      bad++;
      $display("FAIL R1 watchdog cycles=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0;
    end
  endtask

  initial begin
    step(); step();
    rst_n = 1;
    chk("R1 reset state", int'(state_code), 0);
    chk("R1 reset active", int'(active), 0);
    chk("R1 reset in_trans", int'(in_trans), 0);
    chk("R1 reset wake", int'(aux_wake_req), 0);

    thr = 4'd3; en = 1; ent = 1;
    step(); chk("R2 off to idle", int'(state_code), 1);
    step(); chk("R3 idle to enter", int'(state_code), 2);
    chk("R11 in_trans entering", int'(in_trans), 1);
    ticks(5); chk("R5 floor not yet reached", int'(state_code), 2);
    ticks(1); chk("R4 enter to hold", int'(state_code), 3);
    chk("R10 active in hold", int'(active), 1);

    sfu = 1; step(); sfu = 0;
    chk("R8 sfu set", int'(sfu_pending), 1);
    step(); chk("R9 hold to sfu", int'(state_code), 4);
    chk("R8 sfu self clear", int'(sfu_pending), 0);
    ticks(1); chk("R9 sfu back to hold", int'(state_code), 3);

    ent = 0; step();
    chk("R6 hold to leave", int'(state_code), 5);
    chk("R6 wake raised", int'(aux_wake_req), 1);
    chk("R10 inactive in leave", int'(active), 0);
    step(); step(); step();
    chk("R7 wait for ack", int'(state_code), 5);
    chk("R7 wake addr", int'(aux_wake_addr), 32'h600);
    chk("R7 wake data", int'(aux_wake_data), 1);
    ack = 1; step(); ack = 0;
    chk("R7 leave to idle", int'(state_code), 1);
    chk("R11 in_trans clear", int'(in_trans), 0);

    thr = 4'd9; ent = 1; step();
    ticks(4); upd = 1; step(); upd = 0;
    ticks(8); chk("R4 update restarts count", int'(state_code), 2);
    ticks(1); chk("R5 programmed count", int'(state_code), 3);

    ent = 0; step(); en = 0; step();
    chk("R12 leave finishes first", int'(state_code), 5);
    ack = 1; step(); ack = 0;
    chk("R12 back to idle", int'(state_code), 1);
    step(); chk("R12 idle to off", int'(state_code), 0);
    sfu = 1; step(); sfu = 0;
    chk("R8 ignored when off", int'(sfu_pending), 0);

    thr = 4'd0; en = 1; ent = 1; step(); step();
    ticks(2); ent = 0; step();
    chk("R4 abort entry", int'(state_code), 1);
    en = 0; step(); chk("R12 off", int'(state_code), 0);

    en = 1; ent = 1; step(); step(); ticks(6);
    chk("R4 hold again", int'(state_code), 3);
    en = 0; step();
    chk("R12 hold to off", int'(state_code), 0);
    chk("R12 active cleared", int'(active), 0);

    for (int i = 0; i < 4000; i++) begin
      en   = ($urandom_range(0, 19) != 0);
      ent  = ($urandom_range(0, 9) != 0);
      tick = ($urandom_range(0, 2) == 0);
      upd  = ($urandom_range(0, 11) == 0);
      sfu  = ($urandom_range(0, 9) == 0);
      ack  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 99) == 0) thr = IDLE_W'($urandom_range(0, 15));
      step();
    end
    en = 0; ent = 0; tick = 0; upd = 0; sfu = 0; ack = 0;
    step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule